// File: doc/BRIEF.md
# Multi-level DMA transfer sequencer

This block is the counting and addressing core of one DMA channel. It splits a transfer into three nested levels. Buffers of up to 128 bytes make up a block of up to 65536 bytes. Blocks are repeated up to 4096 times, and the full set of repeats is the complete transfer. For every data beat it presents a source and a destination byte address and asks an abstracted bus port to move the beat. It then advances both addresses and the level counters when the port reports that the beat is done. When a block ends, each address also jumps by its own signed offset.

A request comes either from a software strobe or from one selected hardware request line. The trigger mode sets how much work one request starts: one buffer, one block, or the whole set of repeats. A request that arrives while a unit is still running is held and served as soon as that unit ends. Each level has a sticky completion flag, and there is also an error flag. Each flag has its own interrupt enable, and each is cleared by writing 1 to its clear bit. Dropping the channel enable stops the channel at the next beat boundary.

The configuration inputs are sampled when the channel enable rises, which loads the base addresses and counters. They must then stay stable until the channel is disabled again.

Top module: `dma_level_seq`

## Requirements
- R1: After reset, beat_req, req_active, irq and every flag are 0, and both addresses and blk_remain are 0.
- R2: trig_mode sets the work done per request. Code 0 runs one buffer, code 1 runs one block, and codes 2 and 3 run every remaining repeat to the end of the transfer. beat_req and req_active fall in the cycle after the beat that ends the unit.
- R3: buf_len gives the buffer length in bytes (1 to 128). A buffer ends after buf_len bytes or at the end of a block, whichever comes first, and sets flag bit 0. A block end sets flag bit 1.
- R4: blk_len gives the block length in bytes as a plain binary value (1 to 65536). Each beat moves 2^beat_sz bytes. blk_remain shows the bytes still to move in the current block and reloads to blk_len when a block ends.
- R5: rep_cnt (1 to 4096) gives the number of blocks. The beat that ends the last block sets flag bit 2 (repeat set done) and flag bit 3 (transfer complete), and the channel then ignores further requests until it is re-enabled.
- R6: At a block end, each address becomes its own post-beat address plus its own 17-bit two's-complement offset (src_ofs or dst_ofs). An offset of zero continues contiguously.
- R7: Each address mode code works as follows: 0 holds the address, 1 increments it, 2 decrements it, and 3 holds it. The step is 2^step bytes for a step code from 0 to 3. Both addresses start at their bases when the channel enable rises.
- R8: Flags are sticky. A 1 in flag_clr clears the matching bit, and a flag being set in the same cycle takes priority over the clear. irq is high while any flag has its enable bit set in irq_en.
- R9: With use_hw low only sw_trig requests work. With use_hw high, hw_req[req_sel] also does, and the other lines are ignored. req_active is high exactly while a unit is being served.
- R10: A request that arrives while a unit runs is held in one pending slot. The next unit starts without a new request once the current one ends.
- R11: Clearing chan_en during a unit stops the channel before the next beat. blk_remain and the addresses stay frozen, and no flag is set.
- R12: A beat_done with beat_err set does not advance the counters. It sets flag bit 4, ends the unit, and blocks further requests until the channel is re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; a rising edge loads the configuration |
| sw_trig | input | 1 | Software request strobe |
| use_hw | input | 1 | Allow the selected hardware request line |
| hw_req | input | NUM_HW | Hardware request lines |
| req_sel | input | SEL_W | Index of the hardware request line |
| trig_mode | input | 2 | Work per request |
| buf_len | input | BUF_W | Buffer length in bytes |
| blk_len | input | BLK_W | Block length in bytes |
| rep_cnt | input | REP_W | Number of blocks |
| beat_sz | input | 2 | Beat size code, 2^code bytes |
| src_base | input | AW | Source start address |
| dst_base | input | AW | Destination start address |
| src_mode | input | 2 | Source address mode |
| src_step | input | 2 | Source step code |
| dst_mode | input | 2 | Destination address mode |
| dst_step | input | 2 | Destination step code |
| src_ofs | input | OFS_W | Signed source block offset |
| dst_ofs | input | OFS_W | Signed destination block offset |
| irq_en | input | 5 | Per-flag interrupt enables |
| flag_clr | input | 5 | Write-1 flag clear |
| beat_done | input | 1 | Bus port finished the current beat |
| beat_err | input | 1 | Qualifies beat_done as failed |
| beat_req | output | 1 | Beat requested at the current addresses |
| src_addr | output | AW | Current source byte address |
| dst_addr | output | AW | Current destination byte address |
| blk_remain | output | BLK_W | Bytes left in the current block |
| req_active | output | 1 | A request is being served |
| flags | output | 5 | Sticky flags: buffer, block, repeat, complete, error |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume the block is configured legally. buf_len and blk_len are nonzero multiples of the beat size, rep_cnt is nonzero, and no configuration input changes while the channel is enabled. Under those conditions a served unit never shows a zero remaining count. The bench sets every configuration only while chan_en is low and picks lengths as multiples of 2^beat_sz. It sweeps every trigger mode, two beat sizes and three mixes of address modes and offsets, and adds directed runs at the largest block and the largest repeat count.

// File: rtl/dxs_pkg.sv
package dxs_pkg;

   typedef enum logic [1:0] {
      TRG_BUFFER = 2'd0,
      TRG_BLOCK  = 2'd1,
      TRG_REPEAT = 2'd2,
      TRG_FULL   = 2'd3
   } trig_mode_e;

   localparam logic [1:0] AM_HOLD = 2'd0;
   localparam logic [1:0] AM_UP   = 2'd1;
   localparam logic [1:0] AM_DOWN = 2'd2;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READY = 2'd1,
      ST_RUN   = 2'd2,
      ST_STOP  = 2'd3
   } chan_state_e;

   localparam int FLG_BUF   = 0;
   localparam int FLG_BLK   = 1;
   localparam int FLG_REP   = 2;
   localparam int FLG_CTC   = 3;
   localparam int FLG_ERR   = 4;
   localparam int NUM_FLAGS = 5;

   typedef struct packed {
      logic buf_end;
      logic blk_end;
      logic rep_end;
   } level_ev_t;

endpackage

// File: rtl/dxs_req_sel.sv
module dxs_req_sel #(
   parameter int NUM_HW = 34,
   parameter int SEL_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              take,
   input  logic              sw_trig,
   input  logic              use_hw,
   input  logic [NUM_HW-1:0] hw_req,
   input  logic [SEL_W-1:0]  req_sel,
   output logic              pend
);
   localparam int EXT = 1 << SEL_W;

   logic [EXT-1:0] hw_ext;
   logic           hw_hit;
   logic           req_in;

   assign hw_ext = EXT'(hw_req);

   generate
      if (NUM_HW == EXT) begin : g_full_range
         assign hw_hit = hw_ext[req_sel];
      end else begin : g_part_range
         assign hw_hit = (32'(req_sel) < NUM_HW) & hw_ext[req_sel];
      end
   endgenerate

   assign req_in = sw_trig | (use_hw & hw_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend <= 1'b0;
      else if (flush)  pend <= 1'b0;
      else             pend <= (pend & ~take) | req_in;
   end
endmodule

// File: rtl/dxs_level_cnt.sv
module dxs_level_cnt
   import dxs_pkg::*;
#(
   parameter int BUF_W = 8,
   parameter int BLK_W = 17,
   parameter int REP_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             beat,
   input  logic [1:0]       beat_sz,
   input  logic [BUF_W-1:0] buf_len,
   input  logic [BLK_W-1:0] blk_len,
   input  logic [REP_W-1:0] rep_cnt,
   output logic [BLK_W-1:0] blk_left,
   output level_ev_t        ev
);
   logic [BUF_W-1:0] buf_left;
   logic [REP_W-1:0] rep_left;
   logic [BLK_W-1:0] bytes_blk;
   logic [BUF_W-1:0] bytes_buf;
   logic             last_of_blk;
   logic             last_of_buf;
   logic             last_rep;

   assign bytes_blk   = BLK_W'(1) << beat_sz;
   assign bytes_buf   = BUF_W'(1) << beat_sz;
   assign last_of_blk = blk_left <= bytes_blk;
   assign last_of_buf = buf_left <= bytes_buf;
   assign last_rep    = rep_left <= REP_W'(1);

   always_comb begin
      ev.blk_end = beat & last_of_blk;
      ev.buf_end = beat & (last_of_buf | last_of_blk);
      ev.rep_end = beat & last_of_blk & last_rep;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_left <= '0;
         blk_left <= '0;
         rep_left <= '0;
      end else if (load) begin
         buf_left <= buf_len;
         blk_left <= blk_len;
         rep_left <= rep_cnt;
      end else if (beat) begin
         buf_left <= ev.buf_end ? buf_len : buf_left - bytes_buf;
         blk_left <= ev.blk_end ? blk_len : blk_left - bytes_blk;
         if (ev.blk_end) rep_left <= rep_left - REP_W'(1);
      end
   end
endmodule

// File: rtl/dxs_addr_gen.sv
module dxs_addr_gen
   import dxs_pkg::*;
#(
   parameter int AW = 32,
   parameter int OW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          advance,
   input  logic          blk_end,
   input  logic [1:0]    mode,
   input  logic [1:0]    step,
   input  logic [AW-1:0] base,
   input  logic [OW-1:0] ofs,
   output logic [AW-1:0] addr
);
   logic [AW-1:0] delta;
   logic [AW-1:0] ofs_ext;
   logic [AW-1:0] stepped;
   logic [AW-1:0] nxt;

   assign delta   = AW'(1) << step;
   assign ofs_ext = {{(AW-OW){ofs[OW-1]}}, ofs};

   always_comb begin
      case (mode)
         AM_UP:   stepped = addr + delta;
         AM_DOWN: stepped = addr - delta;
         default: stepped = addr;
      endcase
      nxt = blk_end ? stepped + ofs_ext : stepped;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr <= '0;
      else if (load)    addr <= base;
      else if (advance) addr <= nxt;
   end
endmodule

// File: rtl/dxs_flags.sv
module dxs_flags #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] en,
   output logic [N-1:0] flags,
   output logic         irq
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= 1'b0;
            else if (set[i]) q <= 1'b1;
            else if (clr[i]) q <= 1'b0;
         end
         assign flags[i] = q;
      end
   endgenerate

   assign irq = |(flags & en);
endmodule

// File: rtl/dma_level_seq.sv
module dma_level_seq
   import dxs_pkg::*;
#(
   parameter int AW     = 32,
   parameter int NUM_HW = 34,
   parameter int BUF_W  = 8,
   parameter int BLK_W  = 17,
   parameter int REP_W  = 13,
   parameter int OFS_W  = 17,
   localparam int SEL_W = (NUM_HW > 1) ? $clog2(NUM_HW) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              sw_trig,
   input  logic              use_hw,
   input  logic [NUM_HW-1:0] hw_req,
   input  logic [SEL_W-1:0]  req_sel,
   input  logic [1:0]        trig_mode,
   input  logic [BUF_W-1:0]  buf_len,
   input  logic [BLK_W-1:0]  blk_len,
   input  logic [REP_W-1:0]  rep_cnt,
   input  logic [1:0]        beat_sz,
   input  logic [AW-1:0]     src_base,
   input  logic [AW-1:0]     dst_base,
   input  logic [1:0]        src_mode,
   input  logic [1:0]        src_step,
   input  logic [1:0]        dst_mode,
   input  logic [1:0]        dst_step,
   input  logic [OFS_W-1:0]  src_ofs,
   input  logic [OFS_W-1:0]  dst_ofs,
   input  logic [4:0]        irq_en,
   input  logic [4:0]        flag_clr,
   input  logic              beat_done,
   input  logic              beat_err,
   output logic              beat_req,
   output logic [AW-1:0]     src_addr,
   output logic [AW-1:0]     dst_addr,
   output logic [BLK_W-1:0]  blk_remain,
   output logic              req_active,
   output logic [4:0]        flags,
   output logic              irq
);
   generate
      if (AW < OFS_W) begin : g_bad_aw
         $error("dma_level_seq: AW must be at least OFS_W");
      end
      if (NUM_HW < 2) begin : g_bad_hw
         $error("dma_level_seq: NUM_HW must be at least 2");
      end
      if (BUF_W < 4 || BLK_W < 4 || REP_W < 1) begin : g_bad_cnt
         $error("dma_level_seq: counter widths too small for an 8-byte beat");
      end
   endgenerate

   chan_state_e    st, st_nxt;
   level_ev_t      ev;
   logic           pend;
   logic           load;
   logic           take;
   logic           beat;
   logic           err_hit;
   logic           unit_end;
   logic [4:0]     flag_set;

   logic [AW-1:0]    base_a [2];
   logic [AW-1:0]    addr_a [2];
   logic [1:0]       mode_a [2];
   logic [1:0]       step_a [2];
   logic [OFS_W-1:0] ofs_a  [2];

   assign load     = (st == ST_IDLE) & chan_en;
   assign take     = (st == ST_READY) & chan_en & pend;
   assign beat_req = (st == ST_RUN) & chan_en;
   assign beat     = beat_req & beat_done & ~beat_err;
   assign err_hit  = beat_req & beat_done & beat_err;

   always_comb begin
      case (trig_mode_e'(trig_mode))
         TRG_BUFFER: unit_end = ev.buf_end;
         TRG_BLOCK:  unit_end = ev.blk_end;
         default:    unit_end = ev.rep_end;
      endcase
   end

   always_comb begin
      st_nxt = st;
      if (!chan_en) begin
         st_nxt = ST_IDLE;
      end else begin
         case (st)
            ST_IDLE:  st_nxt = ST_READY;
            ST_READY: if (pend) st_nxt = ST_RUN;
            ST_RUN: begin
               if (err_hit || ev.rep_end) st_nxt = ST_STOP;
               else if (unit_end)         st_nxt = ST_READY;
            end
            default:  st_nxt = ST_STOP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nxt;
   end

   assign req_active = (st == ST_RUN);

   dxs_req_sel #(.NUM_HW(NUM_HW), .SEL_W(SEL_W)) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (st == ST_IDLE),
      .take    (take),
      .sw_trig (sw_trig),
      .use_hw  (use_hw),
      .hw_req  (hw_req),
      .req_sel (req_sel),
      .pend    (pend)
   );

   dxs_level_cnt #(.BUF_W(BUF_W), .BLK_W(BLK_W), .REP_W(REP_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .beat     (beat),
      .beat_sz  (beat_sz),
      .buf_len  (buf_len),
      .blk_len  (blk_len),
      .rep_cnt  (rep_cnt),
      .blk_left (blk_remain),
      .ev       (ev)
   );

   assign base_a[0] = src_base;
   assign base_a[1] = dst_base;
   assign mode_a[0] = src_mode;
   assign mode_a[1] = dst_mode;
   assign step_a[0] = src_step;
   assign step_a[1] = dst_step;
   assign ofs_a[0]  = src_ofs;
   assign ofs_a[1]  = dst_ofs;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_side
         dxs_addr_gen #(.AW(AW), .OW(OFS_W)) u_addr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .advance (beat),
            .blk_end (ev.blk_end),
            .mode    (mode_a[g]),
            .step    (step_a[g]),
            .base    (base_a[g]),
            .ofs     (ofs_a[g]),
            .addr    (addr_a[g])
         );
      end
   endgenerate

   assign src_addr = addr_a[0];
   assign dst_addr = addr_a[1];

   always_comb begin
      flag_set          = '0;
      flag_set[FLG_BUF] = ev.buf_end;
      flag_set[FLG_BLK] = ev.blk_end;
      flag_set[FLG_REP] = ev.rep_end;
      flag_set[FLG_CTC] = ev.rep_end;
      flag_set[FLG_ERR] = err_hit;
   end

   dxs_flags #(.N(NUM_FLAGS)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (flag_clr),
      .en    (irq_en),
      .flags (flags),
      .irq   (irq)
   );
endmodule

// File: rtl/dxs_checker.sv
module dxs_checker #(
   parameter int AW    = 32,
   parameter int BLK_W = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chan_en,
   input logic             beat_done,
   input logic [4:0]       flag_clr,
   input logic             beat_req,
   input logic             req_active,
   input logic [AW-1:0]    src_addr,
   input logic [AW-1:0]    dst_addr,
   input logic [BLK_W-1:0] blk_remain,
   input logic [4:0]       flags
);
   AST_BEAT_IN_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      beat_req |-> req_active); // R9

   AST_REMAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      req_active |-> (blk_remain != '0)); // R4

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (|flags) |=> ((($past(flags) & ~$past(flag_clr)) & ~flags) == 5'b0)); // R8

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_active && !beat_done) |=> ($stable(src_addr) && $stable(dst_addr))); // R7

   AST_BUF_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> $past(beat_done)); // R3

   AST_ABORT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> ((flags & ~$past(flags)) == 5'b0)); // R11

   AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[4]) |-> !req_active); // R12
endmodule

bind dma_level_seq dxs_checker #(.AW(AW), .BLK_W(BLK_W)) u_dxs_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .chan_en    (chan_en),
   .beat_done  (beat_done),
   .flag_clr   (flag_clr),
   .beat_req   (beat_req),
   .req_active (req_active),
   .src_addr   (src_addr),
   .dst_addr   (dst_addr),
   .blk_remain (blk_remain),
   .flags      (flags)
);

// File: tb/test_dma_level_seq.sv
module test_dma_level_seq;
   localparam int AW = 32, NHW = 34, SW = 6, BW = 8, KW = 17, RW = 13, OW = 17;

   logic clk = 1'b0, rst_n = 1'b0;
   logic chan_en = 0, sw_trig = 0, use_hw = 0, beat_done = 0, beat_err = 0;
   logic [NHW-1:0] hw_req = '0;
   logic [SW-1:0]  req_sel = '0;
   logic [1:0]     trig_mode = 0, beat_sz = 0, src_mode = 0, src_step = 0, dst_mode = 0, dst_step = 0;
   logic [BW-1:0]  buf_len = 0;
   logic [KW-1:0]  blk_len = 0;
   logic [RW-1:0]  rep_cnt = 0;
   logic [AW-1:0]  src_base = 0, dst_base = 0;
   logic [OW-1:0]  src_ofs = 0, dst_ofs = 0;
   logic [4:0]     irq_en = 0, flag_clr = 0;
   logic           beat_req, req_active, irq;
   logic [AW-1:0]  src_addr, dst_addr;
   logic [KW-1:0]  blk_remain;
   logic [4:0]     flags;

   int errors = 0, checks = 0;
   bit timed_out = 0;
   logic [31:0] m_src, m_dst;
   int m_buf, m_blk, m_rep;

   always #2 clk = ~clk;

   dma_level_seq i_dma_level_seq (
      .clk, .rst_n, .chan_en, .sw_trig, .use_hw, .hw_req, .req_sel, .trig_mode,
      .buf_len, .blk_len, .rep_cnt, .beat_sz, .src_base, .dst_base, .src_mode,
      .src_step, .dst_mode, .dst_step, .src_ofs, .dst_ofs, .irq_en, .flag_clr,
      .beat_done, .beat_err, .beat_req, .src_addr, .dst_addr, .blk_remain,
      .req_active, .flags, .irq);

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int delta(input int mode, input int step);
      if (mode == 1) return 1 << step;
      if (mode == 2) return -(1 << step);
      return 0;
   endfunction

   task automatic configure(input int mode, input int bsz, input int bl, input int kl, input int rc,
                            input int sm, input int ss, input int dm, input int ds,
                            input int so, input int dof, input int sb, input int db);
      chan_en = 0;
      @(negedge clk);
      trig_mode = 2'(mode); beat_sz = 2'(bsz); buf_len = BW'(bl); blk_len = KW'(kl);
      rep_cnt = RW'(rc); src_mode = 2'(sm); src_step = 2'(ss); dst_mode = 2'(dm);
      dst_step = 2'(ds); src_ofs = OW'(so); dst_ofs = OW'(dof);
      src_base = 32'(sb); dst_base = 32'(db);
      chan_en = 1;
      @(negedge clk);
   endtask

   // Full transfer driven and scored against the arithmetic model.
   task automatic run_transfer(input int mode, input int bsz, input int bl, input int kl, input int rc,
                               input int sm, input int ss, input int dm, input int ds,
                               input int so, input int dof, input int sb, input int db);
      bit full = 0;
      int units = 0;
      int bytes = 1 << bsz;
      configure(mode, bsz, bl, kl, rc, sm, ss, dm, ds, so, dof, sb, db);
      chk(src_addr == 32'(sb) && dst_addr == 32'(db), "R7 load", src_addr, sb);
      chk(blk_remain == KW'(kl), "R4 load", blk_remain, kl);
      m_src = 32'(sb); m_dst = 32'(db); m_buf = bl; m_blk = kl; m_rep = rc;
      while (!full && units < 10000) begin
         logic [4:0] exp_f = '0;
         bit udone = 0;
         int guard = 0;
         units++;
         sw_trig = 1;
         @(negedge clk);
         sw_trig = 0;
         while (!udone && guard < 20000) begin
            @(negedge clk);
            beat_done = 0;
            guard++;
            if (beat_req) begin
               bit be, ke, re;
               chk(src_addr == m_src && dst_addr == m_dst, "R6/R7 addr", {src_addr, dst_addr}, {m_src, m_dst});
               chk(blk_remain == KW'(m_blk), "R4 remain", blk_remain, m_blk);
               beat_done = 1;
               ke = (m_blk <= bytes);
               be = (m_buf <= bytes) || ke;
               re = ke && (m_rep == 1);
               m_src = m_src + 32'(delta(sm, ss));
               m_dst = m_dst + 32'(delta(dm, ds));
               if (ke) begin
                  m_src = m_src + 32'(so);
                  m_dst = m_dst + 32'(dof);
               end
               m_buf = be ? bl : m_buf - bytes;
               m_blk = ke ? kl : m_blk - bytes;
               if (ke) m_rep = m_rep - 1;
               exp_f = exp_f | {1'b0, re, re, ke, be};
               case (mode)
                  0: udone = be;
                  1: udone = ke;
                  default: udone = re;
               endcase
               full = re;
            end
         end
         @(negedge clk);
         beat_done = 0;
         chk(!beat_req && !req_active, "R2 unit end", {beat_req, req_active}, 0);
         chk(flags == exp_f, "R3 flags", flags, exp_f);
         if (full) chk(flags[3] && flags[2], "R5 complete", flags, exp_f);
         flag_clr = 5'h1f;
         @(negedge clk);
         flag_clr = 0;
         chk(flags == 0, "R8 clear", flags, 0);
      end
      if (full) begin
         sw_trig = 1;
         @(negedge clk);
         sw_trig = 0;
         repeat (3) @(negedge clk);
         chk(!req_active, "R5 stop", req_active, 0);
      end
      chan_en = 0;
      @(negedge clk);
   endtask

   task automatic tests();
      int cnt;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(!beat_req && !req_active && !irq && flags == 0, "R1 ctrl", {beat_req, req_active, irq, flags}, 0);
      chk(src_addr == 0 && dst_addr == 0 && blk_remain == 0, "R1 data", src_addr, 0);

      // R2 sweep: trigger modes x beat sizes x address/offset mixes
      for (int m = 0; m < 4; m++)
         for (int b = 0; b < 2; b++)
            for (int k = 0; k < 3; k++)
               case (k)
                  0: run_transfer(m, b, 2 << b, 6 << b, 2, 1, 0, 2, 2, 16, -8, 'h1000, 'h8000);
                  1: run_transfer(m, b, 4 << b, 5 << b, 3, 0, 0, 1, 3, -3, 0, 'h2000, 'h9000);
                  default: run_transfer(m, b, 128, 3 << b, 1, 2, 1, 1, 0, 0, 100, 'h3000, 'hA000);
               endcase

      // R4 largest block, R5 largest repeat count
      run_transfer(1, 3, 128, 65536, 1, 1, 3, 1, 3, 0, 0, 'h10000, 'h40000);
      run_transfer(2, 3, 8, 8, 4096, 1, 3, 2, 3, -8, 24, 'h100000, 'h200000);

      // R10 pending request served after the running unit
      configure(0, 0, 2, 8, 1, 1, 0, 1, 0, 0, 0, 'h500, 'h600);
      sw_trig = 1; @(negedge clk); sw_trig = 0; @(negedge clk);
      cnt = 0;
      for (int i = 0; i < 20; i++) begin
         sw_trig = (i == 0);
         beat_done = beat_req;
         if (beat_req) cnt++;
         @(negedge clk);
      end
      sw_trig = 0; beat_done = 0;
      chk(cnt == 4, "R10 beats", cnt, 4);
      chk(blk_remain == 4, "R10 remain", blk_remain, 4);
      flag_clr = 5'h1f; @(negedge clk); flag_clr = 0;

      // R11 abort freezes counters, raises no flag
      configure(3, 0, 16, 8, 2, 1, 0, 1, 0, 0, 0, 'h700, 'h800);
      sw_trig = 1; @(negedge clk); sw_trig = 0;
      cnt = 0;
      while (cnt < 3) begin
         @(negedge clk);
         beat_done = beat_req;
         if (beat_req) cnt++;
      end
      @(negedge clk);
      beat_done = 0; chan_en = 0;
      repeat (3) @(negedge clk);
      chk(blk_remain == 5, "R11 remain", blk_remain, 5);
      chk(src_addr == 'h703, "R11 addr", src_addr, 'h703);
      chk(flags == 0 && !beat_req && !req_active, "R11 flags", flags, 0);

      // R9 hardware request selection
      configure(0, 0, 2, 4, 1, 1, 0, 1, 0, 0, 0, 'h40, 'h80);
      use_hw = 1; req_sel = 6'd33;
      hw_req[5] = 1; @(negedge clk); hw_req[5] = 0;
      repeat (4) @(negedge clk);
      chk(!req_active && !beat_req, "R9 unselected", req_active, 0);
      hw_req[33] = 1; @(negedge clk); hw_req[33] = 0; @(negedge clk);
      chk(req_active && beat_req, "R9 selected", req_active, 1);
      beat_done = 1; @(negedge clk); @(negedge clk); beat_done = 0;
      @(negedge clk);
      chk(flags == 5'b00001 && !req_active, "R9 served", flags, 1);
      use_hw = 0;
      flag_clr = 5'h1f; @(negedge clk); flag_clr = 0;

      // R12 error beat, R8 enables and per-bit clear
      configure(0, 0, 4, 8, 1, 1, 0, 1, 0, 0, 0, 'hC0, 'hD0);
      sw_trig = 1; @(negedge clk); sw_trig = 0; @(negedge clk);
      beat_done = 1; beat_err = 1; @(negedge clk);
      beat_done = 0; beat_err = 0;
      chk(flags == 5'b10000 && !req_active, "R12 flag", flags, 'h10);
      chk(blk_remain == 8 && src_addr == 'hC0, "R12 no advance", blk_remain, 8);
      sw_trig = 1; @(negedge clk); sw_trig = 0;
      repeat (3) @(negedge clk);
      chk(!beat_req, "R12 blocked", beat_req, 0);
      irq_en = 5'b00001; @(negedge clk);
      chk(!irq, "R8 masked", irq, 0);
      irq_en = 5'b10000; @(negedge clk);
      chk(irq, "R8 enabled", irq, 1);
      flag_clr = 5'b00001; @(negedge clk); flag_clr = 0;
      chk(flags == 5'b10000, "R8 other bit kept", flags, 'h10);
      flag_clr = 5'b10000; @(negedge clk); flag_clr = 0;
      chk(flags == 0 && !irq, "R8 cleared", flags, 0);
      irq_en = 0; chan_en = 0;
      @(negedge clk);
   endtask

   initial begin
      fork
         tests();
         begin
            repeat (190000) @(posedge clk);
            timed_out = 1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule